// File: doc/BRIEF.md
# Seven-Bit Software Watchdog

This block guards a processor against runaway code. It holds a 7-bit down counter and an enable flag in a single 8-bit control register. An external prescaler supplies a one-cycle tick strobe, and each tick lowers the counter by one. Software must rewrite the register often enough that counter bit 6 never falls from 1 to 0. When the watchdog is enabled and that bit does fall, the block drives an active-low reset request for a fixed number of clock cycles.

The enable flag can only be set. Once it is set, the watchdog stays on until the block itself is reset. A strap input chooses the mode. In strap mode the flag is already set when reset ends. In software mode, software sets the flag by writing bit 7. Because expiry is tied to the fall of bit 6, only the 64 load values from 40h to 7Fh give useful timeouts. The usual refresh write is therefore C0h to FFh. A write that loads a value with bit 6 clear, while bit 6 is set and the watchdog is enabled, forces a reset at once.

No data flows through the block, so there is no valid/ready interface. The register port is a plain single-cycle write strobe with a read bus that is always valid. The tick and the reset request are plain level signals.

Top module: `wdt7_guard`

## Requirements
- R1: While `rst_n` is low and just after it is released with `hw_mode_i` = 0, `rd_data_o` reads 7Fh (enable bit 7 = 0, counter bits 6..0 = 7Fh) and `rst_req_n_o` is high.
- R2: A cycle with `tick_i` = 1 and `wr_en_i` = 0 lowers the counter by one, with 00h wrapping to 7Fh. A cycle with neither strobe leaves the counter unchanged.
- R3: A cycle with `wr_en_i` = 1 loads `wr_data_i[6:0]` into the counter. If `tick_i` is also high in that cycle, the tick is discarded and the write wins.
- R4: Writing `wr_data_i[7]` = 1 sets the enable bit (read back in bit 7). Writing bit 7 = 0 never clears it.
- R5: If the watchdog is enabled and a tick takes the counter from 40h to 3Fh, `rst_req_n_o` is low from the next clock edge onward.
- R6: If the enable bit is set (or set by the same write) and a write loads a counter value with bit 6 = 0 while the current counter has bit 6 = 1, `rst_req_n_o` is low from the next clock edge onward.
- R7: Each reset request keeps `rst_req_n_o` low for exactly `PULSE_CYCLES` clock cycles and then returns it high.
- R8: While the enable bit is 0, the counter still counts, but `rst_req_n_o` stays high.
- R9: With `hw_mode_i` = 1 during reset, `rd_data_o` reads FFh after reset, and the watchdog expires without any software write of bit 7.
- R10: `rd_data_o` shows the register contents (enable bit in bit 7, counter in bits 6..0) in the same cycle in which they change, with no extra read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_mode_i | input | 1 | Strap: 1 = enabled out of reset |
| tick_i | input | 1 | Prescaled decrement strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data: bit 7 enable, bits 6..0 counter |
| rd_data_o | output | 8 | Register read-back |
| rst_req_n_o | output | 1 | Active-low reset request pulse |

## Verification
Every result has a latency of one clock edge. A write or tick sampled at an edge shows up in `rd_data_o` after that edge. An expiry sampled at an edge pulls `rst_req_n_o` low after the same edge, and it stays low for exactly `PULSE_CYCLES` edges. The bench drives its inputs on the falling edge and samples on the next falling edge, which is always one rising edge later. Pulse width is measured by counting the falling-edge samples that see the line low.

// File: rtl/wdt7_pkg.sv
package wdt7_pkg;
  localparam int unsigned CNT_W  = 7;
  localparam int unsigned REG_W  = CNT_W + 1;
  localparam int unsigned EXP_BIT = CNT_W - 1;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic active;
    cnt_t count;
  } ctl_reg_t;
endpackage

// File: rtl/wdt7_counter.sv
module wdt7_counter
  import wdt7_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic load_i,
  input  cnt_t load_val_i,
  output cnt_t cnt_q_o,
  output cnt_t cnt_d_o
);
  cnt_t cnt_q, cnt_d;

  // A load takes priority over a tick in the same cycle.
  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = load_val_i;
    else if (tick_i) cnt_d = cnt_q - cnt_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

  assign cnt_q_o = cnt_q;
  assign cnt_d_o = cnt_d;
endmodule

// File: rtl/wdt7_arm.sv
module wdt7_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_mode_i,
  input  logic set_i,
  output logic active_q_o,
  output logic active_d_o
);
  logic active_q;

  // The flag can only be set; clearing it needs a block reset.
  assign active_d_o = active_q | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= hw_mode_i;
    else        active_q <= active_d_o;
  end

  assign active_q_o = active_q;
endmodule

// File: rtl/wdt7_pulse.sv
module wdt7_pulse #(
  parameter int unsigned PULSE_CYCLES = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic rst_req_n_o
);
  localparam int unsigned PW_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [PW_W-1:0] PW_LOAD = PW_W'(PULSE_CYCLES);

  logic [PW_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   remain_q <= '0;
    else if (fire_i)              remain_q <= PW_LOAD;
    else if (remain_q != '0)      remain_q <= remain_q - PW_W'(1);
  end

  assign rst_req_n_o = (remain_q == '0);
endmodule

// File: rtl/wdt7_guard.sv
module wdt7_guard
  import wdt7_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 1500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_mode_i,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       rst_req_n_o
);
  cnt_t     cnt_q, cnt_d;
  logic     active_q, active_d;
  logic     fire;
  ctl_reg_t rd_view;

  wdt7_counter i_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .load_i     (wr_en_i),
    .load_val_i (wr_data_i[CNT_W-1:0]),
    .cnt_q_o    (cnt_q),
    .cnt_d_o    (cnt_d)
  );

  wdt7_arm i_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_mode_i  (hw_mode_i),
    .set_i      (wr_en_i & wr_data_i[REG_W-1]),
    .active_q_o (active_q),
    .active_d_o (active_d)
  );

  // Expiry: the top counter bit falls while the watchdog is (or becomes) enabled.
  assign fire = active_d & cnt_q[EXP_BIT] & ~cnt_d[EXP_BIT];

  wdt7_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) i_pulse (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire_i      (fire),
    .rst_req_n_o (rst_req_n_o)
  );

  assign rd_view   = '{active: active_q, count: cnt_q};
  assign rd_data_o = rd_view;
endmodule

// File: rtl/wdt7_guard_chk.sv
module wdt7_guard_chk #(
  parameter int unsigned PULSE_CYCLES = 1500
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic       rst_req_n_o
);
  int unsigned low_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            low_len <= 0;
    else if (!rst_req_n_o) low_len <= low_len + 1;
    else                   low_len <= 0;
  end

  a_r2_tick_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !wr_en_i) |=> (rd_data_o[6:0] == 7'($past(rd_data_o[6:0]) - 7'd1)));

  a_r3_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (rd_data_o[6:0] == $past(wr_data_i[6:0])));

  a_r4_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[7] |=> rd_data_o[7]);

  a_r5_expiry_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[7] && tick_i && !wr_en_i && rd_data_o[6:0] == 7'h40) |=> !rst_req_n_o);

  a_r6_forced_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (rd_data_o[7] || wr_data_i[7]) && rd_data_o[6] && !wr_data_i[6]) |=> !rst_req_n_o);

  a_r7_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_n_o) |-> (low_len >= PULSE_CYCLES));

  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data_o[7] && !wr_en_i) |=> !$fell(rst_req_n_o));
endmodule

bind wdt7_guard wdt7_guard_chk #(.PULSE_CYCLES(PULSE_CYCLES)) i_chk (.*);

// File: tb/test_wdt7_guard.sv
module test_wdt7_guard;
  localparam int unsigned PULSE = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_mode = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       rst_req_n;

  int unsigned n_checks = 0;
  int unsigned n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  wdt7_guard #(.PULSE_CYCLES(PULSE)) i_wdt7_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_mode_i   (hw_mode),
    .tick_i      (tick),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .rd_data_o   (rd_data),
    .rst_req_n_o (rst_req_n)
  );

  // {wr_en, wr_data[7:0], tick, expected rd_data[7:0], expected rst_req_n}
  localparam int NV = 12;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 8'h00, 1'b1, 8'h7E, 1'b1},  // R2 tick from reset value
    {1'b1, 8'h45, 1'b0, 8'h45, 1'b1},  // R3 load, still off
    {1'b0, 8'h00, 1'b1, 8'h44, 1'b1},  // R2
    {1'b0, 8'h00, 1'b1, 8'h43, 1'b1},  // R2
    {1'b0, 8'h00, 1'b1, 8'h42, 1'b1},  // R2
    {1'b0, 8'h00, 1'b1, 8'h41, 1'b1},  // R2
    {1'b0, 8'h00, 1'b1, 8'h40, 1'b1},  // R2
    {1'b0, 8'h00, 1'b1, 8'h3F, 1'b1},  // R8 boundary crossed while off
    {1'b1, 8'hC2, 1'b0, 8'hC2, 1'b1},  // R4 enable by write
    {1'b0, 8'h00, 1'b1, 8'hC1, 1'b1},  // R2
    {1'b0, 8'h00, 1'b1, 8'hC0, 1'b1},  // R2
    {1'b0, 8'h00, 1'b1, 8'hBF, 1'b0}   // R5 expiry 40h->3Fh
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge; sample at the next falling edge (one rising edge later).
  task automatic step(input logic w, input logic [7:0] d, input logic t);
    wr_en = w; wr_data = d; tick = t;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00; tick = 1'b0;
  endtask

  // Count low samples; the first was already seen by the caller.
  task automatic measure_pulse(input string req);
    int unsigned n = 1;
    for (int i = 0; i < PULSE + 8; i++) begin
      @(negedge clk);
      if (!rst_req_n) n++;
      else break;
    end
    check(req, n, PULSE);
  endtask

  task automatic do_reset(input logic hw);
    @(negedge clk);
    hw_mode = hw;
    rst_n = 1'b0;
    #3;
    check("R1 in reset rd", rd_data, hw ? 8'hFF : 8'h7F);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    check("R1 rd after reset", rd_data, 8'h7F);
    check("R1 request idle", rst_req_n, 1'b1);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][18], VEC[k][17:10], VEC[k][9]);
      check($sformatf("R10 table rd row %0d", k), rd_data, VEC[k][8:1]);
      check($sformatf("R5 table request row %0d", k), rst_req_n, VEC[k][0]);
    end
    measure_pulse("R7 expiry pulse width");

    // R4: clearing bit 7 is ignored, counter bits still load
    step(1'b1, 8'h7A, 1'b0);
    check("R4 enable stays set", rd_data, 8'hFA);
    // R3: write beats a simultaneous tick
    step(1'b1, 8'hD0, 1'b1);
    check("R3 write wins over tick", rd_data, 8'hD0);
    check("R3 no request", rst_req_n, 1'b1);
    // R6: forced reset by loading bit 6 clear
    step(1'b1, 8'h90, 1'b0);
    check("R6 forced rd", rd_data, 8'h90);
    check("R6 forced request", rst_req_n, 1'b0);
    measure_pulse("R7 forced pulse width");
    // bit 6 already clear: loading another clear value starts nothing
    step(1'b1, 8'h80, 1'b0);
    check("R6 no edge no request", rst_req_n, 1'b1);
    step(1'b0, 8'h00, 1'b1);
    check("R2 wrap 00h to 7Fh", rd_data, 8'hFF);
    check("R2 wrap no request", rst_req_n, 1'b1);
    step(1'b0, 8'h00, 1'b0);
    check("R2 idle hold", rd_data, 8'hFF);

    // R9: strap mode
    do_reset(1'b1);
    check("R9 enabled from reset", rd_data, 8'hFF);
    step(1'b1, 8'h41, 1'b0);
    check("R9 load", rd_data, 8'hC1);
    step(1'b0, 8'h00, 1'b1);
    step(1'b0, 8'h00, 1'b1);
    check("R9 expiry rd", rd_data, 8'hBF);
    check("R9 expiry request", rst_req_n, 1'b0);
    measure_pulse("R7 strap pulse width");

    // R1 again in software mode
    do_reset(1'b0);
    check("R1 software mode off", rd_data, 8'h7F);
    step(1'b1, 8'h00, 1'b0);
    check("R8 off load no request", rst_req_n, 1'b1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule